// File: doc/BRIEF.md
# Fault Auto-Restart Timer

This block guards a switching power converter against a shorted output or a broken feedback loop. A comparator outside the block reports whether the feedback voltage is below the auto-restart threshold. While the flag is set, the block counts oscillator ticks. A tick on which feedback is healthy clears the count. If the count reaches the fault timeout, the block removes the switching enable.

After the timeout the block runs a recovery burst. Switching stays off for a long window, then is allowed for a short window, and this repeats for as long as the fault persists. A high-line input lengthens both windows by one fifth (integer floor). The flag is taken once at the start of each window and holds for that window. One healthy feedback tick inside an on-window ends recovery at once.

All durations are tick counts set by parameters. The defaults are small so that a simulation stays short.

Top module: `fault_autorestart`

## Requirements
- R1: After reset, `sw_en` is 1 and `in_auto_restart` is 0.
- R2: In normal operation the fault count advances only on a tick with `fb_low`=1. A tick with `fb_low`=0 clears it, so FAULT_TICKS-1 low ticks followed by a high tick never trip.
- R3: On the FAULT_TICKS-th consecutive low tick, `sw_en` goes to 0 and `in_auto_restart` goes to 1 at that tick's clock edge.
- R4: At low line an off-window lasts OFF_TICKS ticks. On its last tick `sw_en` returns to 1 while `in_auto_restart` stays 1.
- R5: At low line an on-window lasts ON_TICKS ticks. If `fb_low` is 1 on every one of them, the last tick starts a new off-window (`sw_en`=0).
- R6: When `high_line`=1 at the start of a window, its length is base+base/5 (integer floor). With the defaults that is 48 off-ticks and 12 on-ticks.
- R7: `high_line` is sampled only on the tick that opens a window. Changes during the window do not alter its length.
- R8: A tick with `fb_low`=0 during an on-window returns the block to normal operation at that edge (`in_auto_restart`=0, `sw_en`=1) with a fresh fault count.
- R9: During an off-window `fb_low` is ignored, and healthy ticks neither shorten the window nor leave recovery.
- R10: Outputs change only at a clock edge on which `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle oscillator tick |
| fb_low | input | 1 | Feedback is below the auto-restart threshold |
| high_line | input | 1 | Input line is high; lengthens recovery windows |
| sw_en | output | 1 | Switching allowed |
| in_auto_restart | output | 1 | Block is in the recovery burst |

## Verification
Every result is due at the clock edge of the tick that causes it. The state and the counter are the only registers on the path, and both outputs decode straight from the state. The driver raises `tick` at a falling edge and pushes the expected output pair. It then holds a tick-free cycle and pushes the same pair again, which checks R10. The monitor compares two nanoseconds after each rising edge, so each comparison reads the state settled by exactly that edge. Window lengths are checked at their final tick and at the tick before it, which catches an off-by-one error in either direction.

// File: rtl/ar_pkg.sv
package ar_pkg;
   typedef enum logic [1:0] {
      AR_RUN = 2'd0,
      AR_OFF = 2'd1,
      AR_ON  = 2'd2
   } ar_state_e;
endpackage

// File: rtl/ar_counter.sv
module ar_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         clr,
   input  logic [W-1:0] limit,
   output logic         last
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (clr)  cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + W'(1);
   end

   // limit is at least 1, guaranteed by elaboration checks in the top
   assign last = (cnt_q == (limit - W'(1)));
endmodule

// File: rtl/ar_limit_sel.sv
module ar_limit_sel
   import ar_pkg::*;
#(
   parameter int W           = 8,
   parameter int FAULT_TICKS = 20,
   parameter int OFF_TICKS   = 40,
   parameter int ON_TICKS    = 10,
   parameter bit STRETCH_EN  = 1'b1
) (
   input  ar_state_e    state,
   input  logic         hl_q,
   output logic [W-1:0] limit
);
   localparam int OFF_HL = OFF_TICKS + OFF_TICKS / 5;
   localparam int ON_HL  = ON_TICKS + ON_TICKS / 5;

   logic [W-1:0] off_lim, on_lim;

   generate
      if (STRETCH_EN) begin : g_stretch
         assign off_lim = hl_q ? W'(OFF_HL) : W'(OFF_TICKS);
         assign on_lim  = hl_q ? W'(ON_HL)  : W'(ON_TICKS);
      end else begin : g_flat
         logic unused_hl;
         assign unused_hl = hl_q;
         assign off_lim   = W'(OFF_TICKS);
         assign on_lim    = W'(ON_TICKS);
      end
   endgenerate

   always_comb begin
      case (state)
         AR_OFF:  limit = off_lim;
         AR_ON:   limit = on_lim;
         default: limit = W'(FAULT_TICKS);
      endcase
   end
endmodule

// File: rtl/ar_fsm.sv
module ar_fsm
   import ar_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      fb_low,
   input  logic      high_line,
   input  logic      last,
   output ar_state_e state,
   output logic      hl_q,
   output logic      clr,
   output logic      sw_en,
   output logic      in_ar
);
   ar_state_e state_n;
   logic      hl_n;

   always_comb begin
      state_n = state;
      hl_n    = hl_q;
      clr     = 1'b0;
      if (tick) begin
         case (state)
            AR_RUN: begin
               if (!fb_low) begin
                  clr = 1'b1;
               end else if (last) begin
                  state_n = AR_OFF;
                  clr     = 1'b1;
                  hl_n    = high_line;
               end
            end
            AR_OFF: begin
               if (last) begin
                  state_n = AR_ON;
                  clr     = 1'b1;
                  hl_n    = high_line;
               end
            end
            AR_ON: begin
               if (!fb_low) begin
                  state_n = AR_RUN;
                  clr     = 1'b1;
               end else if (last) begin
                  state_n = AR_OFF;
                  clr     = 1'b1;
                  hl_n    = high_line;
               end
            end
            default: begin
               state_n = AR_RUN;
               clr     = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= AR_RUN;
         hl_q  <= 1'b0;
      end else begin
         state <= state_n;
         hl_q  <= hl_n;
      end
   end

   assign sw_en = (state != AR_OFF);
   assign in_ar = (state != AR_RUN);
endmodule

// File: rtl/fault_autorestart.sv
module fault_autorestart
   import ar_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int FAULT_TICKS = 20,
   parameter int OFF_TICKS   = 40,
   parameter int ON_TICKS    = 10,
   parameter bit HL_STRETCH  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic fb_low,
   input  logic high_line,
   output logic sw_en,
   output logic in_auto_restart
);
   localparam int OFF_MAX = OFF_TICKS + (HL_STRETCH ? OFF_TICKS / 5 : 0);
   localparam int ON_MAX  = ON_TICKS + (HL_STRETCH ? ON_TICKS / 5 : 0);
   localparam int CAP     = 1 << CNT_W;

   generate
      if (CNT_W < 2 || CNT_W > 30) begin : g_bad_w
         $error("CNT_W out of range");
      end
      if (FAULT_TICKS < 1 || OFF_TICKS < 1 || ON_TICKS < 1) begin : g_bad_min
         $error("durations must be at least one tick");
      end
      if (FAULT_TICKS >= CAP || OFF_MAX >= CAP || ON_MAX >= CAP) begin : g_bad_fit
         $error("a duration does not fit in CNT_W bits");
      end
   endgenerate

   ar_state_e        state;
   logic             hl_q, clr, last;
   logic [CNT_W-1:0] limit;

   ar_limit_sel #(
      .W(CNT_W), .FAULT_TICKS(FAULT_TICKS), .OFF_TICKS(OFF_TICKS),
      .ON_TICKS(ON_TICKS), .STRETCH_EN(HL_STRETCH)
   ) u_lim (
      .state(state), .hl_q(hl_q), .limit(limit)
   );

   ar_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(tick), .clr(clr),
      .limit(limit), .last(last)
   );

   ar_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .tick(tick), .fb_low(fb_low),
      .high_line(high_line), .last(last), .state(state), .hl_q(hl_q),
      .clr(clr), .sw_en(sw_en), .in_ar(in_auto_restart)
   );
endmodule

// File: rtl/ar_checker.sv
module ar_checker (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic fb_low,
   input logic sw_en,
   input logic in_ar
);
   a_r10_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(sw_en) && $stable(in_ar)));

   a_r3_entry_goes_off: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ar) |-> !sw_en);

   a_r9_off_stays_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_en |=> in_ar);

   a_r8_good_fb_exits_on_window: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !fb_low && in_ar && sw_en) |=> (!in_ar && sw_en));

   a_r2_normal_keeps_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ar |-> sw_en);

   a_r2_good_fb_no_trip: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !fb_low && !in_ar) |=> !in_ar);
endmodule

bind fault_autorestart ar_checker u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .fb_low(fb_low),
   .sw_en(sw_en), .in_ar(in_auto_restart)
);

// File: tb/tb_fault_autorestart.sv
module tb_fault_autorestart;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, fb_low = 1'b0, high_line = 1'b0;
   logic sw_en, in_auto_restart;

   typedef struct {
      bit    sw;
      bit    ar;
      string tag;
   } exp_t;

   exp_t q[$];
   int   n_run = 0, n_fail = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   fault_autorestart dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .fb_low(fb_low),
      .high_line(high_line), .sw_en(sw_en), .in_auto_restart(in_auto_restart)
   );

   // driver: one tick cycle plus one idle cycle (idle checks R10)
   task automatic step(input bit fbl, input bit hl, input bit esw,
                       input bit ear, input string tag);
      @(negedge clk);
      tick = 1'b1; fb_low = fbl; high_line = hl;
      q.push_back('{esw, ear, tag});
      @(negedge clk);
      tick = 1'b0; fb_low = ~fbl; high_line = ~hl;
      q.push_back('{esw, ear, "R10"});
   endtask

   task automatic steps(input int n, input bit fbl, input bit hl, input bit esw,
                        input bit ear, input string tag);
      for (int i = 0; i < n; i++) step(fbl, hl, esw, ear, tag);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (sw_en !== e.sw || in_auto_restart !== e.ar) begin
               n_fail++;
               $display("FAIL %s: sw_en/in_ar actual %b/%b expected %b/%b at %0t",
                        e.tag, sw_en, in_auto_restart, e.sw, e.ar, $time);
            end
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state, checked on a tick-free cycle
      @(negedge clk);
      q.push_back('{1'b1, 1'b0, "R1"});
      @(negedge clk);

      // R2: 19 low ticks then a healthy one, twice, no trip
      steps(19, 1'b1, 1'b0, 1'b1, 1'b0, "R2");
      step(1'b0, 1'b0, 1'b1, 1'b0, "R2");
      steps(19, 1'b1, 1'b0, 1'b1, 1'b0, "R2");
      step(1'b0, 1'b0, 1'b1, 1'b0, "R2");

      // R3: trip on the 20th consecutive low tick, low line latched
      steps(19, 1'b1, 1'b0, 1'b1, 1'b0, "R3");
      step(1'b1, 1'b0, 1'b0, 1'b1, "R3");

      // R4/R9: off window of 40 ticks with healthy feedback mixed in
      for (int i = 0; i < 39; i++)
         step(i[0], 1'b0, 1'b0, 1'b1, (i[0] ? "R4" : "R9"));
      step(1'b0, 1'b0, 1'b1, 1'b1, "R4");

      // R5: 10-tick on window with fault; high line taken at its end
      steps(9, 1'b1, 1'b0, 1'b1, 1'b1, "R5");
      step(1'b1, 1'b1, 1'b0, 1'b1, "R5");

      // R6/R7: stretched off window of 48; high line dropped mid-window
      steps(46, 1'b1, 1'b0, 1'b0, 1'b1, "R7");
      step(1'b1, 1'b0, 1'b0, 1'b1, "R6");
      step(1'b1, 1'b1, 1'b1, 1'b1, "R6");

      // R6/R7: stretched on window of 12 ticks
      steps(11, 1'b1, 1'b0, 1'b1, 1'b1, "R6");
      step(1'b1, 1'b0, 1'b0, 1'b1, "R6");

      // R7: low-line off window back to 40 despite high line before it
      steps(39, 1'b1, 1'b1, 1'b0, 1'b1, "R7");
      step(1'b1, 1'b0, 1'b1, 1'b1, "R7");

      // R8: healthy tick inside the on window exits at once
      steps(3, 1'b1, 1'b0, 1'b1, 1'b1, "R8");
      step(1'b0, 1'b0, 1'b1, 1'b0, "R8");
      // fresh fault count after exit
      steps(19, 1'b1, 1'b0, 1'b1, 1'b0, "R8");
      step(1'b0, 1'b0, 1'b1, 1'b0, "R8");
      steps(19, 1'b1, 1'b0, 1'b1, 1'b0, "R3");
      step(1'b1, 1'b0, 1'b0, 1'b1, "R3");

      wait (q.size() == 0);
      @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule